// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This controller erases a single flash block and confirms that the erase succeeded. A start strobe launches it, together with a one-hot block selection and the block's address bounds. The controller raises the array's write-enable and holds it for a settling time. It then runs a timed erase pulse. The erase-setup bit rises first, followed by the erase bit. They fall in the reverse order, and a programmed wait follows each change. A watchdog-enable output is raised one cycle before the pulse sequence begins and stays up until setup has dropped and its wait has ended.

After the pulse the controller enters verify mode and walks the block one 16-bit word at a time. For each word it issues a dummy write of 0x00FF, waits, and then reads the word back. Any word that is not all ones ends the walk, and a further full erase pulse is run. Once the attempt limit is used up, the controller reports failure instead. If every word reads as all ones, the controller reports success. Every wait and the attempt limit are parameters counted in clock cycles. The block does not program the array to zeros before erasing.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy, done, fail, every flash control bit, the watchdog enable, memWr, memRd and selOut are all 0.
- R2: A start is accepted only when blockSel has exactly one bit set. A zero select or a select with several bits set leaves busy low and every output unchanged. While busy, selOut shows the accepted select, and at all other times it is 0.
- R3: In the cycle after an accepted start, swEnable rises and stays high for T_SWE cycles before any other control bit or the watchdog enable changes. swEnable stays high until the cycle that carries the result pulse.
- R4: wdtEnable rises alone for one cycle before eraseSetup rises. It stays high through the whole pulse and through the T_SUCLR wait after eraseSetup falls, and it is low while eraseVerify is high.
- R5: Each attempt drives eraseSetup high alone for T_SETUP cycles and then eraseOn as well for T_PULSE cycles. eraseOn then falls, eraseSetup stays high for T_HOLD cycles, and it then falls.
- R6: Verify raises eraseVerify for T_VSET cycles. For each word it then gives one memWr cycle, with memWdata 0x00FF at memAddr, then T_DWAIT idle cycles, then one memRd cycle at the same address. The first address is blkStart, and each further word is 2 bytes higher.
- R7: A read word that is not 0xFFFF ends the walk. eraseVerify falls and T_VCLR cycles follow. If fewer than MAX_TRY attempts have been made, a full new attempt starts at R4, and the walk restarts at blkStart.
- R8: When the failing attempt is attempt MAX_TRY (attempts are counted from 1), swEnable and busy fall and fail is high for exactly one cycle.
- R9: When the word at blkEnd-2 reads 0xFFFF, eraseVerify falls and T_VCLR cycles follow. Then swEnable and busy fall and done is high for exactly one cycle.
- R10: busy is high from the cycle after an accepted start until the result cycle. A start strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start strobe |
| blockSel | input | SEL_W | One-hot block selection |
| blkStart | input | ADDR_W | First byte address of the block |
| blkEnd | input | ADDR_W | Byte address one word past the block |
| memRdata | input | DATA_W | Word read back from the array |
| swEnable | output | 1 | Software write enable to the array |
| eraseSetup | output | 1 | Erase setup bit |
| eraseOn | output | 1 | Erase pulse bit |
| eraseVerify | output | 1 | Erase verify mode bit |
| wdtEnable | output | 1 | Watchdog enable |
| selOut | output | SEL_W | Selected block, held while busy |
| memWr | output | 1 | Dummy write strobe |
| memRd | output | 1 | Verify read strobe |
| memAddr | output | ADDR_W | Verify address |
| memWdata | output | DATA_W | Dummy write data (0x00FF) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle failure pulse |

## Verification
The bench runs a behavioural flash model in which each word needs its own number of erase pulses. This lets it exercise a clean first-pass erase, a retry caused by a word in the middle of the block, and an exhaustion at the attempt limit. An off-by-one in the attempt counter would give one attempt too many or too few, and the per-cycle comparison would report the surplus or missing watchdog cycle. Select values with zero or two bits set, and a start strobe sent mid-sequence, would make a design that fails to filter them raise busy or restart the timeline. A design that tests the wrong last address would either read a word past blkEnd or report done one word early.

// File: rtl/fes_pkg.sv
package fes_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SWE, S_ARM, S_SETUP, S_PULSE, S_HOLD, S_SUCLR,
    S_VSET, S_DWR, S_DWAIT, S_READ, S_VCLR_OK, S_VCLR_BAD
  } seqState_e;

  typedef enum logic [2:0] {
    W_SWE, W_SETUP, W_PULSE, W_HOLD, W_SUCLR, W_VSET, W_DWAIT, W_VCLR
  } waitSel_e;

  typedef struct packed {
    logic     loadWait;
    waitSel_e waitSel;
    logic     latchBlk;
    logic     rewind;
    logic     nextAddr;
    logic     incTry;
  } ctlStrobe_t;

endpackage

// File: rtl/fes_datapath.sv
module fes_datapath
  import fes_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int SEL_W   = 8,
  parameter int CNT_W   = 20,
  parameter int T_SWE   = 10,
  parameter int T_SETUP = 20,
  parameter int T_PULSE = 1000,
  parameter int T_HOLD  = 10,
  parameter int T_SUCLR = 10,
  parameter int T_VSET  = 6,
  parameter int T_DWAIT = 2,
  parameter int T_VCLR  = 4,
  parameter int MAX_TRY = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        stb,
  input  logic              busy,
  input  logic [SEL_W-1:0]  blockSel,
  input  logic [ADDR_W-1:0] blkStart,
  input  logic [ADDR_W-1:0] blkEnd,
  input  logic [DATA_W-1:0] memRdata,
  output logic              selOk,
  output logic              waitDone,
  output logic              lastWord,
  output logic              wordErased,
  output logic              tryLast,
  output logic [SEL_W-1:0]  selOut,
  output logic [ADDR_W-1:0] memAddr
);

  localparam int TRY_W = $clog2(MAX_TRY + 1) + 1;
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(DATA_W / 8);

  logic [CNT_W-1:0]  waitCnt;
  logic [CNT_W-1:0]  loadVal;
  logic [ADDR_W-1:0] startReg;
  logic [ADDR_W-1:0] lastReg;
  logic [SEL_W-1:0]  selReg;
  logic [TRY_W-1:0]  tryCnt;

  assign selOk = (blockSel != '0) && ((blockSel & (blockSel - SEL_W'(1))) == '0);

  always_comb begin
    unique case (stb.waitSel)
      W_SWE:   loadVal = CNT_W'(T_SWE - 1);
      W_SETUP: loadVal = CNT_W'(T_SETUP - 1);
      W_PULSE: loadVal = CNT_W'(T_PULSE - 1);
      W_HOLD:  loadVal = CNT_W'(T_HOLD - 1);
      W_SUCLR: loadVal = CNT_W'(T_SUCLR - 1);
      W_VSET:  loadVal = CNT_W'(T_VSET - 1);
      W_DWAIT: loadVal = CNT_W'(T_DWAIT - 1);
      default: loadVal = CNT_W'(T_VCLR - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waitCnt <= '0;
    end else if (stb.loadWait) begin
      waitCnt <= loadVal;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - CNT_W'(1);
    end
  end

  assign waitDone = (waitCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startReg <= '0;
      lastReg  <= '0;
      selReg   <= '0;
    end else if (stb.latchBlk) begin
      startReg <= blkStart;
      lastReg  <= blkEnd - WORD_STEP;
      selReg   <= blockSel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memAddr <= '0;
    end else if (stb.rewind) begin
      memAddr <= startReg;
    end else if (stb.nextAddr) begin
      memAddr <= memAddr + WORD_STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tryCnt <= TRY_W'(1);
    end else if (stb.latchBlk) begin
      tryCnt <= TRY_W'(1);
    end else if (stb.incTry) begin
      tryCnt <= tryCnt + TRY_W'(1);
    end
  end

  assign tryLast    = (tryCnt >= TRY_W'(MAX_TRY));
  assign lastWord   = (memAddr == lastReg);
  assign wordErased = (memRdata == {DATA_W{1'b1}});
  assign selOut     = busy ? selReg : '0;

endmodule

// File: rtl/fes_control.sv
module fes_control
  import fes_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic       selOk,
  input  logic       waitDone,
  input  logic       lastWord,
  input  logic       wordErased,
  input  logic       tryLast,
  output ctlStrobe_t stb,
  output logic       swEnable,
  output logic       eraseSetup,
  output logic       eraseOn,
  output logic       eraseVerify,
  output logic       wdtEnable,
  output logic       memWr,
  output logic       memRd,
  output logic       busy,
  output logic       done,
  output logic       fail
);

  seqState_e state, stateNxt;
  logic doneSet, failSet;

  always_comb begin
    stateNxt = state;
    stb      = '{loadWait: 1'b0, waitSel: W_SWE, latchBlk: 1'b0,
                 rewind: 1'b0, nextAddr: 1'b0, incTry: 1'b0};
    doneSet  = 1'b0;
    failSet  = 1'b0;
    unique case (state)
      S_IDLE: if (startReq && selOk) begin
        stateNxt     = S_SWE;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_SWE;
        stb.latchBlk = 1'b1;
      end
      S_SWE: if (waitDone) stateNxt = S_ARM;
      S_ARM: begin
        stateNxt     = S_SETUP;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_SETUP;
      end
      S_SETUP: if (waitDone) begin
        stateNxt     = S_PULSE;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_PULSE;
      end
      S_PULSE: if (waitDone) begin
        stateNxt     = S_HOLD;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_HOLD;
      end
      S_HOLD: if (waitDone) begin
        stateNxt     = S_SUCLR;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_SUCLR;
      end
      S_SUCLR: if (waitDone) begin
        stateNxt     = S_VSET;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_VSET;
        stb.rewind   = 1'b1;
      end
      S_VSET: if (waitDone) stateNxt = S_DWR;
      S_DWR: begin
        stateNxt     = S_DWAIT;
        stb.loadWait = 1'b1;
        stb.waitSel  = W_DWAIT;
      end
      S_DWAIT: if (waitDone) stateNxt = S_READ;
      S_READ: begin
        stb.waitSel = W_VCLR;
        if (!wordErased) begin
          stateNxt     = S_VCLR_BAD;
          stb.loadWait = 1'b1;
        end else if (lastWord) begin
          stateNxt     = S_VCLR_OK;
          stb.loadWait = 1'b1;
        end else begin
          stateNxt     = S_DWR;
          stb.nextAddr = 1'b1;
        end
      end
      S_VCLR_OK: if (waitDone) begin
        stateNxt = S_IDLE;
        doneSet  = 1'b1;
      end
      S_VCLR_BAD: if (waitDone) begin
        if (tryLast) begin
          stateNxt = S_IDLE;
          failSet  = 1'b1;
        end else begin
          stateNxt   = S_ARM;
          stb.incTry = 1'b1;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
      fail  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneSet;
      fail  <= failSet;
    end
  end

  assign busy        = (state != S_IDLE);
  assign swEnable    = busy;
  assign wdtEnable   = (state == S_ARM) || (state == S_SETUP) || (state == S_PULSE) ||
                       (state == S_HOLD) || (state == S_SUCLR);
  assign eraseSetup  = (state == S_SETUP) || (state == S_PULSE) || (state == S_HOLD);
  assign eraseOn     = (state == S_PULSE);
  assign eraseVerify = (state == S_VSET) || (state == S_DWR) || (state == S_DWAIT) ||
                       (state == S_READ);
  assign memWr       = (state == S_DWR);
  assign memRd       = (state == S_READ);

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int SEL_W   = 8,
  parameter int CNT_W   = 20,
  parameter int T_SWE   = 10,
  parameter int T_SETUP = 20,
  parameter int T_PULSE = 1000,
  parameter int T_HOLD  = 10,
  parameter int T_SUCLR = 10,
  parameter int T_VSET  = 6,
  parameter int T_DWAIT = 2,
  parameter int T_VCLR  = 4,
  parameter int MAX_TRY = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [SEL_W-1:0]  blockSel,
  input  logic [ADDR_W-1:0] blkStart,
  input  logic [ADDR_W-1:0] blkEnd,
  input  logic [DATA_W-1:0] memRdata,
  output logic              swEnable,
  output logic              eraseSetup,
  output logic              eraseOn,
  output logic              eraseVerify,
  output logic              wdtEnable,
  output logic [SEL_W-1:0]  selOut,
  output logic              memWr,
  output logic              memRd,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              busy,
  output logic              done,
  output logic              fail
);

  ctlStrobe_t stb;
  logic selOk, waitDone, lastWord, wordErased, tryLast;

  assign memWdata = DATA_W'(8'hFF);

  fes_control ctl_i (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .selOk(selOk),
    .waitDone(waitDone), .lastWord(lastWord), .wordErased(wordErased),
    .tryLast(tryLast), .stb(stb), .swEnable(swEnable), .eraseSetup(eraseSetup),
    .eraseOn(eraseOn), .eraseVerify(eraseVerify), .wdtEnable(wdtEnable),
    .memWr(memWr), .memRd(memRd), .busy(busy), .done(done), .fail(fail)
  );

  fes_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W), .CNT_W(CNT_W),
    .T_SWE(T_SWE), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD),
    .T_SUCLR(T_SUCLR), .T_VSET(T_VSET), .T_DWAIT(T_DWAIT), .T_VCLR(T_VCLR),
    .MAX_TRY(MAX_TRY)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .busy(busy), .blockSel(blockSel),
    .blkStart(blkStart), .blkEnd(blkEnd), .memRdata(memRdata), .selOk(selOk),
    .waitDone(waitDone), .lastWord(lastWord), .wordErased(wordErased),
    .tryLast(tryLast), .selOut(selOut), .memAddr(memAddr)
  );

endmodule

// File: rtl/fes_checker.sv
module fes_checker #(
  parameter int SEL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             swEnable,
  input logic             eraseSetup,
  input logic             eraseOn,
  input logic             eraseVerify,
  input logic             wdtEnable,
  input logic [SEL_W-1:0] selOut,
  input logic             memWr,
  input logic             memRd,
  input logic             busy,
  input logic             done,
  input logic             fail
);

  p_ctl_needs_swe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eraseSetup || eraseVerify || wdtEnable) |-> swEnable);

  p_setup_guarded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eraseSetup |-> wdtEnable);

  p_wdt_off_verify_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eraseVerify |-> !wdtEnable);

  p_wdt_before_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eraseSetup) |-> $past(wdtEnable));

  p_pulse_in_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eraseOn |-> eraseSetup);

  p_access_in_verify_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (memWr || memRd) |-> (eraseVerify && !eraseSetup && !(memWr && memRd)));

  p_fail_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (!busy && !swEnable && !done) ##1 !fail);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !swEnable) ##1 !done);

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $onehot(selOut));

  p_sel_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (selOut == '0));

endmodule

bind flash_erase_seq fes_checker #(.SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .swEnable(swEnable), .eraseSetup(eraseSetup),
  .eraseOn(eraseOn), .eraseVerify(eraseVerify), .wdtEnable(wdtEnable),
  .selOut(selOut), .memWr(memWr), .memRd(memRd), .busy(busy), .done(done),
  .fail(fail)
);

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;

  localparam int AW = 16, DW = 16, SW = 8;
  localparam int TX = 3, TY = 2, TZ = 5, TH = 2, TS = 2, TV = 2, TD = 1, TC = 2;
  localparam int NMAX = 3;
  localparam int NWORDS = 4;
  localparam logic [AW-1:0] BASE = 16'h0100;

  logic clk = 1'b0, rst_n = 1'b0, startReq = 1'b0;
  logic [SW-1:0] blockSel = '0;
  logic [AW-1:0] blkStart = BASE, blkEnd = BASE + 16'(2 * NWORDS);
  logic [DW-1:0] memRdata;
  logic swEnable, eraseSetup, eraseOn, eraseVerify, wdtEnable, memWr, memRd;
  logic busy, done, fail;
  logic [SW-1:0] selOut;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;

  always #10 clk = ~clk;

  flash_erase_seq #(
    .ADDR_W(AW), .DATA_W(DW), .SEL_W(SW), .CNT_W(8),
    .T_SWE(TX), .T_SETUP(TY), .T_PULSE(TZ), .T_HOLD(TH), .T_SUCLR(TS),
    .T_VSET(TV), .T_DWAIT(TD), .T_VCLR(TC), .MAX_TRY(NMAX)
  ) dut_i (.*);

  // behavioural flash: word i reads all ones once needPulses[i] pulses have ended
  int needPulses [NWORDS];
  int pulsesSeen;
  logic prevErase;
  always @(posedge clk) begin
    if (prevErase && !eraseOn && swEnable) pulsesSeen <= pulsesSeen + 1;
    prevErase <= eraseOn;
  end
  always_comb begin
    int idx;
    idx = int'(memAddr - BASE) / 2;
    if (idx < 0 || idx >= NWORDS) memRdata = 16'h5A5A;
    else memRdata = (pulsesSeen >= needPulses[idx]) ? 16'hFFFF : 16'h5A5A;
  end

  // expected output vector: {busy,swe,setup,pulse,verify,wdt,wr,rd,done,fail}
  typedef struct {
    logic [9:0]    vec;
    logic [AW-1:0] addr;
    logic [SW-1:0] sel;
    string         tag;
  } exp_t;
  exp_t expQ[$];
  int total = 0, bad = 0;
  logic [SW-1:0] curSel;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic pushN(input int n, input logic [9:0] v, input logic [AW-1:0] a,
                       input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.vec = v; e.addr = a; e.sel = v[9] ? curSel : '0; e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  // builds the whole expected timeline of one accepted run
  task automatic buildRun();
    int attempt = 1;
    bit ok = 0;
    pushN(TX, 10'b11_0000_0000, '0, "R3");
    forever begin
      int word = 0;
      pushN(1,  10'b11_0001_0000, '0, "R4");
      pushN(TY, 10'b11_1001_0000, '0, "R5");
      pushN(TZ, 10'b11_1101_0000, '0, "R5");
      pushN(TH, 10'b11_1001_0000, '0, "R5");
      pushN(TS, 10'b11_0001_0000, '0, "R4");
      pushN(TV, 10'b11_0010_0000, '0, "R6");
      ok = 1;
      while (word < NWORDS) begin
        logic [AW-1:0] a = BASE + 16'(2 * word);
        pushN(1,  10'b11_0010_1000, a, "R6");
        pushN(TD, 10'b11_0010_0000, '0, "R6");
        pushN(1,  10'b11_0010_0100, a, "R6");
        if (attempt < needPulses[word]) begin ok = 0; break; end
        word++;
      end
      pushN(TC, 10'b11_0000_0000, '0, ok ? "R9" : "R7");
      if (ok) begin pushN(1, 10'b00_0000_0010, '0, "R9"); break; end
      if (attempt >= NMAX) begin pushN(1, 10'b00_0000_0001, '0, "R8"); break; end
      attempt++;
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      logic [9:0] act;
      act = {busy, swEnable, eraseSetup, eraseOn, eraseVerify, wdtEnable,
             memWr, memRd, done, fail};
      if (expQ.size() > 0) e = expQ.pop_front();
      else begin e.vec = '0; e.addr = '0; e.sel = '0; e.tag = "R10-idle"; end
      check(e.tag, 64'(act), 64'(e.vec));
      check({e.tag, " sel R2"}, 64'(selOut), 64'(e.sel));
      if (e.vec[3] || e.vec[2]) check({e.tag, " addr"}, 64'(memAddr), 64'(e.addr));
      if (e.vec[3]) check("R6 wdata", 64'(memWdata), 64'h00FF);
    end
  end

  task automatic startRun(input logic [SW-1:0] sel, input bit accept);
    @(posedge clk) #2;
    startReq = 1'b1; blockSel = sel;
    @(posedge clk) #2;
    startReq = 1'b0;
    pulsesSeen = 0;
    if (accept) begin curSel = sel; buildRun(); end
  endtask

  task automatic waitIdle();
    while (expQ.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pulsesSeen = 0; prevErase = 0; curSel = '0;
    for (int i = 0; i < NWORDS; i++) needPulses[i] = 1;
    repeat (3) @(posedge clk);
    #2;
    // R1: quiet during reset
    check("R1 reset", 64'({busy, swEnable, eraseSetup, eraseOn, eraseVerify, wdtEnable,
                           memWr, memRd, done, fail, selOut}), 64'h0);
    rst_n = 1'b1;
    #20;
    check("R1 after reset", 64'({busy, swEnable, wdtEnable, done, fail}), 64'h0);

    // R2: zero and multi-bit selects rejected
    startRun(8'h00, 0);
    check("R2 zero sel busy", 64'(busy), 64'h0);
    startRun(8'h21, 0);
    check("R2 two bits busy", 64'(busy), 64'h0);
    repeat (3) @(posedge clk);

    // R9: clean erase on the first attempt
    startRun(8'h04, 1);
    waitIdle();

    // R7 + R10: word 2 needs two pulses; a mid-run start is ignored
    needPulses[2] = 2;
    startRun(8'h10, 1);
    repeat (10) @(posedge clk);
    #2 startReq = 1'b1; blockSel = 8'h01;
    @(posedge clk) #2 startReq = 1'b0;
    check("R10 busy held", 64'(busy), 64'h1);
    waitIdle();

    // R9: only the last word (blkEnd-2) needs a retry
    needPulses[2] = 1; needPulses[3] = 3;
    startRun(8'h80, 1);
    waitIdle();

    // R8: exhaustion, one word never erases within the limit
    needPulses[3] = NMAX + 1;
    startRun(8'h02, 1);
    waitIdle();
    check("R8 idle after fail", 64'({busy, swEnable}), 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule